// File: doc/BRIEF.md
# Read Request Decomposer

This block sits between an upstream read port and a serial-link request queue. It takes one read request, given as a start address and a byte length. It issues that read as one or more sub-requests in ascending address order. Each sub-request stays inside one 4 KB page. Each one is no longer than the configured maximum read size. Each one also fits in the completion buffer space that is free at the moment it is sized.

The block owns a free-byte counter for the completion buffer. It subtracts the size of each sub-request at the moment that sub-request is formed, before it is offered downstream. The data path returns space through a release input once it has drained completion data. Because space is reserved ahead of every read, the completion buffer cannot be overrun. When no space is free, the block waits. After the last sub-request of a request is taken, a one-cycle done pulse marks the end.

Top module: `rd_split_engine`

## Requirements
- R1: No sub-request crosses a 4 KB boundary: (sub_addr_o mod 4096) + sub_len_o <= 4096.
- R2: The size-limit code cfg_mrs_i is sampled when a request is accepted. Code k in 0..5 allows 128 << k bytes, and codes 6 and 7 allow 4096 bytes. No sub-request is longer than the sampled limit.
- R3: A sub-request's length never exceeds the free buffer bytes at the time it is sized. Reserved bytes that have not been released never exceed BUF_BYTES.
- R4: Each sub-request length equals the minimum of four values: bytes left to the next 4 KB boundary, the size limit, the free buffer bytes, and the bytes of the request still unissued. The length is never zero.
- R5: Sub-requests of one request cover it exactly, in ascending order. The first starts at the request address, and each later one starts at the previous address plus the previous length.
- R6: While the free buffer bytes are zero, sub_valid_o stays low.
- R7: While sub_valid_o is high and sub_ready_i is low, sub_valid_o, sub_addr_o and sub_len_o hold their values.
- R8: done_o is high for exactly one cycle, in the cycle after the last sub-request is accepted. For a zero-length request, done_o is high in the cycle after the request is accepted, and no sub-request is issued.
- R9: After reset, req_ready_o is 1, sub_valid_o is 0 and done_o is 0. req_ready_o is high only when no request is in progress.
- R10: A release pulse (rel_valid_i) adds rel_bytes_i to the free space one cycle later. This allows a stalled request to continue with sub-requests sized to the returned space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Upstream read request valid |
| req_ready_o | output | 1 | Block is idle and takes a request |
| req_addr_i | input | ADDR_W | Request start byte address |
| req_len_i | input | LEN_W | Request length in bytes |
| cfg_mrs_i | input | 3 | Maximum read size code |
| sub_valid_o | output | 1 | Sub-request valid |
| sub_ready_i | input | 1 | Downstream takes sub-request |
| sub_addr_o | output | ADDR_W | Sub-request start address |
| sub_len_o | output | 13 | Sub-request length in bytes |
| rel_valid_i | input | 1 | Buffer space release strobe |
| rel_bytes_i | input | CRD_W | Bytes released |
| done_o | output | 1 | Last sub-request of the request accepted |

## Verification
A stale free-byte count shows up at the ports in one of two ways. It can appear as a sub-request sized above the space actually released. It can also appear as a stall that never clears after a release, and this shows within one sizing cycle. A wrong running address or remaining length shows as a gap, an overlap or a missing or early done pulse in the very next sub-request. The sweep covers addresses just below page ends, every size code, and lengths that exhaust the buffer. The bench models free space and compares every sub-request's address and length at the cycle it is offered.

// File: rtl/rd_split_pkg.sv
package rd_split_pkg;
  localparam int PAGE_LG    = 12;
  localparam int PAGE_BYTES = 1 << PAGE_LG;
  localparam int SUB_W      = PAGE_LG + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_HOLD = 2'd2
  } st_e;

  function automatic logic [SUB_W-1:0] mrs_to_bytes(input logic [2:0] code);
    logic [SUB_W-1:0] b;
    if (code > 3'd5) b = SUB_W'(PAGE_BYTES);
    else             b = SUB_W'(128) << code;
    return b;
  endfunction
endpackage

// File: rtl/rd_split_credit.sv
module rd_split_credit
  import rd_split_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int CRD_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rsv_en_i,
  input  logic [SUB_W-1:0] rsv_bytes_i,
  input  logic             rel_en_i,
  input  logic [CRD_W-1:0] rel_bytes_i,
  output logic [CRD_W-1:0] free_o
);
  localparam int SUM_W = ((CRD_W > SUB_W) ? CRD_W : SUB_W) + 1;

  logic [CRD_W-1:0] free_q;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(free_q);
    if (rel_en_i) sum = sum + SUM_W'(rel_bytes_i);
    if (rsv_en_i) sum = sum - SUM_W'(rsv_bytes_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= CRD_W'(BUF_BYTES);
    else         free_q <= CRD_W'(sum);
  end

  assign free_o = free_q;

  assert_rsv_fits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_en_i |-> (SUM_W'(rsv_bytes_i) <= SUM_W'(free_q)));
  assert_no_overrun_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SUM_W'(free_q) <= SUM_W'(BUF_BYTES));
  assert_release_adds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_en_i && !rsv_en_i) |=> (SUM_W'(free_q) == SUM_W'($past(free_q)) + SUM_W'($past(rel_bytes_i))));
endmodule

// File: rtl/rd_split_size.sv
module rd_split_size
  import rd_split_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CRD_W = 11
) (
  input  logic [PAGE_LG-1:0] page_off_i,
  input  logic [LEN_W-1:0]   rem_i,
  input  logic [2:0]         mrs_i,
  input  logic [CRD_W-1:0]   free_i,
  output logic [SUB_W-1:0]   chunk_o
);
  localparam int W0    = (LEN_W > CRD_W) ? LEN_W : CRD_W;
  localparam int CMP_W = (W0 > SUB_W) ? W0 : SUB_W;

  logic [CMP_W-1:0] to_page, lim, a, b;

  always_comb begin
    to_page = CMP_W'(PAGE_BYTES) - CMP_W'(page_off_i);
    lim     = CMP_W'(mrs_to_bytes(mrs_i));
    a       = (to_page < lim) ? to_page : lim;
    b       = (CMP_W'(free_i) < CMP_W'(rem_i)) ? CMP_W'(free_i) : CMP_W'(rem_i);
    chunk_o = SUB_W'((a < b) ? a : b);
  end
endmodule

// File: rtl/rd_split_ctrl.sv
module rd_split_ctrl
  import rd_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic [2:0]         cfg_mrs_i,
  output logic               sub_valid_o,
  input  logic               sub_ready_i,
  output logic [ADDR_W-1:0]  sub_addr_o,
  output logic [SUB_W-1:0]   sub_len_o,
  output logic               done_o,
  input  logic [SUB_W-1:0]   chunk_i,
  output logic [PAGE_LG-1:0] page_off_o,
  output logic [LEN_W-1:0]   rem_o,
  output logic [2:0]         mrs_o,
  output logic               rsv_en_o
);
  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [2:0]        mrs_q;
  logic [SUB_W-1:0]  len_q;
  logic              done_q;
  logic              take_sub;

  assign take_sub = (st_q == ST_HOLD) && sub_ready_i;
  assign rsv_en_o = (st_q == ST_CALC) && (chunk_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      mrs_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q <= req_addr_i;
          rem_q  <= req_len_i;
          mrs_q  <= cfg_mrs_i;
          if (req_len_i == '0) done_q <= 1'b1;
          else                 st_q   <= ST_CALC;
        end
        ST_CALC: if (rsv_en_o) begin
          len_q <= chunk_i;
          st_q  <= ST_HOLD;
        end
        ST_HOLD: if (take_sub) begin
          addr_q <= addr_q + ADDR_W'(len_q);
          rem_q  <= rem_q - LEN_W'(len_q);
          if (rem_q == LEN_W'(len_q)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= ST_CALC;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign sub_valid_o = (st_q == ST_HOLD);
  assign sub_addr_o  = addr_q;
  assign sub_len_o   = len_q;
  assign done_o      = done_q;
  assign page_off_o  = addr_q[PAGE_LG-1:0];
  assign rem_o       = rem_q;
  assign mrs_o       = mrs_q;

  assert_in_page_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> ((SUB_W+1)'(addr_q[PAGE_LG-1:0]) + (SUB_W+1)'(len_q) <= (SUB_W+1)'(PAGE_BYTES)));
  assert_size_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> (len_q <= mrs_to_bytes(mrs_q)));
  assert_len_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> ((len_q != '0) && (LEN_W'(len_q) <= rem_q)));
  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_valid_o && !sub_ready_i) |=> (sub_valid_o && $stable(sub_addr_o) && $stable(sub_len_o)));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> !req_ready_o);
endmodule

// File: rtl/rd_split_engine.sv
module rd_split_engine
  import rd_split_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 1024,
  localparam int CRD_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [2:0]        cfg_mrs_i,
  output logic              sub_valid_o,
  input  logic              sub_ready_i,
  output logic [ADDR_W-1:0] sub_addr_o,
  output logic [SUB_W-1:0]  sub_len_o,
  input  logic              rel_valid_i,
  input  logic [CRD_W-1:0]  rel_bytes_i,
  output logic              done_o
);
  logic [SUB_W-1:0]   chunk;
  logic [PAGE_LG-1:0] page_off;
  logic [LEN_W-1:0]   rem;
  logic [2:0]         mrs;
  logic               rsv_en;
  logic [CRD_W-1:0]   free;

  rd_split_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_len_i,
    .cfg_mrs_i, .sub_valid_o, .sub_ready_i, .sub_addr_o, .sub_len_o, .done_o,
    .chunk_i(chunk), .page_off_o(page_off), .rem_o(rem), .mrs_o(mrs),
    .rsv_en_o(rsv_en)
  );

  rd_split_size #(.LEN_W(LEN_W), .CRD_W(CRD_W)) i_size (
    .page_off_i(page_off), .rem_i(rem), .mrs_i(mrs), .free_i(free),
    .chunk_o(chunk)
  );

  rd_split_credit #(.BUF_BYTES(BUF_BYTES), .CRD_W(CRD_W)) i_credit (
    .clk_i, .rst_ni, .rsv_en_i(rsv_en), .rsv_bytes_i(chunk),
    .rel_en_i(rel_valid_i), .rel_bytes_i(rel_bytes_i), .free_o(free)
  );

  assert_stall_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free == '0 && !sub_valid_o) |=> !sub_valid_o);
endmodule

// File: tb/test_rd_split_engine.sv
module test_rd_split_engine;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int BUF    = 1024;
  localparam int CRD_W  = $clog2(BUF + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [2:0]        cfg_mrs = '0;
  logic              sub_valid;
  logic              sub_ready = 1'b0;
  logic [ADDR_W-1:0] sub_addr;
  logic [12:0]       sub_len;
  logic              rel_valid = 1'b0;
  logic [CRD_W-1:0]  rel_bytes = '0;
  logic              done;

  int n_chk = 0;
  int n_bad = 0;
  int bfree = BUF;
  int outst = 0;

  always #5 clk = ~clk;

  rd_split_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF)) i_rd_split_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .cfg_mrs_i(cfg_mrs),
    .sub_valid_o(sub_valid), .sub_ready_i(sub_ready), .sub_addr_o(sub_addr),
    .sub_len_o(sub_len), .rel_valid_i(rel_valid), .rel_bytes_i(rel_bytes),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic release_bytes(input int n);
    rel_valid = 1'b1;
    rel_bytes = CRD_W'(n);
    @(negedge clk);
    rel_valid = 1'b0;
    bfree += n;
    outst -= n;
  endtask

  task automatic run_req(input int addr, input int len, input int code);
    int cur = addr;
    int rem = len;
    int mb  = (code > 5) ? 4096 : (128 << code);
    bit after_rel = 1'b0;
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    cfg_mrs   = 3'(code);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_mrs   = ~3'(code);  // must have been latched
    if (len == 0) begin
      chk(done == 1'b1, "R8 zero-length done", done, 1);
      chk(sub_valid == 1'b0, "R8 zero-length no sub", sub_valid, 0);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", done, 0);
      return;
    end
    chk(req_ready == 1'b0, "R9 busy not ready", req_ready, 0);
    while (rem > 0) begin
      int w = 0;
      int exp_len;
      if (bfree == 0) begin
        for (int k = 0; k < 4; k++) begin
          chk(sub_valid == 1'b0, "R6 stall while empty", sub_valid, 0);
          @(negedge clk);
        end
        release_bytes(imin(outst, 384));
        after_rel = 1'b1;
      end
      while (!sub_valid && w < 20) begin
        @(negedge clk);
        w++;
      end
      exp_len = imin(imin(4096 - (cur % 4096), mb), imin(bfree, rem));
      chk(sub_valid == 1'b1, "R4 sub offered", sub_valid, 1);
      chk(int'(sub_addr) == cur, "R5 sub address", sub_addr, cur);
      chk(int'(sub_len) == exp_len, "R4 sub length", sub_len, exp_len);
      chk((cur % 4096) + int'(sub_len) <= 4096, "R1 page bound", (cur % 4096) + int'(sub_len), 4096);
      chk(int'(sub_len) <= mb, "R2 size limit", sub_len, mb);
      chk(int'(sub_len) <= bfree, "R3 free bound", sub_len, bfree);
      if (after_rel) begin
        chk(int'(sub_len) <= 384, "R10 sized to release", sub_len, 384);
        after_rel = 1'b0;
      end
      @(negedge clk);
      chk(sub_valid == 1'b1 && int'(sub_addr) == cur && int'(sub_len) == exp_len,
          "R7 hold stable", sub_len, exp_len);
      sub_ready = 1'b1;
      @(negedge clk);
      sub_ready = 1'b0;
      cur   += exp_len;
      rem   -= exp_len;
      bfree -= exp_len;
      outst += exp_len;
      chk(outst <= BUF, "R3 outstanding bound", outst, BUF);
      if (rem == 0) begin
        chk(done == 1'b1, "R8 done after last", done, 1);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R8 done pulse / R9 idle", done, 0);
      end else begin
        chk(done == 1'b0, "R5 no early done", done, 0);
      end
    end
    if (outst > 0) release_bytes(outst);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int addrs[5] = '{0, 'hF80, 'hFFC, 'h1234, 'h7FF0};
    int lens[6]  = '{0, 1, 128, 300, 4096, 5000};
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
    chk(sub_valid == 1'b0, "R9 reset sub_valid", sub_valid, 0);
    chk(done == 1'b0, "R9 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 5; a++)
        for (int l = 0; l < 6; l++)
          run_req(addrs[a], lens[l], c);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule